// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block picks which of eight interrupt lines, if any, is presented to the processor. The request, mask and in-service vectors are supplied by the surrounding controller. The block drops the masked requests and searches the rest for the one of highest priority. The search starts at a programmable rotation origin and wraps past the top line back to line 0.

The best pending request is then weighed against the best line already in service, using the same rotated order. The processor interrupt is raised only if the pending request strictly outranks every serviced line. The winning line number is presented alongside it.

Two options change the comparison:
- **Nested cascade exception.** When the controller is a master running in special fully nested mode, the in-service bit of the cascade line is left out of the comparison. This lets a nested slave interrupt through.
- **Special mask mode.** In this mode the in-service comparison is dropped entirely.

The decision is combinational. Both outputs are registered once per clock.

Top module: `rpr_top`

## Requirements
- R1: While the asynchronous active-low reset is asserted, irq_o is 0 and line_o is 0, whatever the inputs.
- R2: A request line takes part only if its request bit is 1 and its mask bit is 0. A mask bit of 1 fully blocks that line.
- R3: Relative priority of line L is (L - origin_i) mod 8, and 0 is the highest. The winning request is the unmasked request of lowest relative priority, and line_o carries its absolute line number.
- R4: irq_o and line_o reflect the inputs present at the previous rising clock edge. They do not change between edges.
- R5: irq_o is raised only when the winning request's relative priority is strictly lower than that of the best in-service line. When both are the same line, nothing is raised.
- R6: With an empty in-service vector, any unmasked request raises irq_o.
- R7: When master_i=1 and nest_i=1, in-service bit 2 (the cascade line) is ignored in the comparison. All other in-service bits still count.
- R8: When master_i=0, or when nest_i=0, in-service bit 2 counts like any other line.
- R9: When smask_i=1, the in-service comparison is bypassed, so any unmasked request raises irq_o.
- R10: When irq_o is 0, line_o is 0. With no unmasked request, irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Pending request vector, bit n = line n |
| mask_i | input | 8 | Mask vector, 1 blocks the line |
| insvc_i | input | 8 | In-service vector, bit n = line n |
| origin_i | input | 3 | Line holding relative priority 0 |
| master_i | input | 1 | 1 = controller acts as cascade master |
| nest_i | input | 1 | Special fully nested mode enable |
| smask_i | input | 1 | Special mask mode enable |
| irq_o | output | 1 | Registered interrupt to the processor |
| line_o | output | 3 | Registered winning line number |

## Verification
Rotation and the in-service gate act in the same cycle. The bench therefore drives a rotated origin together with a pending request and an in-service line whose order flips under that rotation. Unrotated, such a request would win; rotated, it must lose, and the reverse case is also driven. The cascade exception is driven in the same cycle with each role and mode setting, so that only the strap decides whether bit 2 counts. Each case is judged on the registered outputs one edge after it is applied.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
   localparam int RPR_LINES   = 8;
   localparam int RPR_CASCADE = 2;
endpackage

// File: rtl/rpr_find.sv
// Rotated search: returns relative index of first set bit from origin, N if none.
module rpr_find #(
   parameter int N = 8,
   parameter int W = $clog2(N)
) (
   input  logic [N-1:0] vec_i,
   input  logic [W-1:0] origin_i,
   output logic [W:0]   rel_o
);
   logic [N-1:0] rot;
   logic [W-1:0] idx;

   always_comb begin
      rot = '0;
      idx = '0;
      for (int i = 0; i < N; i++) begin
         idx    = W'(i) + origin_i;
         rot[i] = vec_i[idx];
      end
      rel_o = (W+1)'(N);
      for (int i = N - 1; i >= 0; i--) begin
         if (rot[i]) rel_o = (W+1)'(i);
      end
   end
endmodule

// File: rtl/rpr_gate.sv
// Compares pending rank against in-service rank; maps winner to absolute line.
module rpr_gate #(
   parameter int N = 8,
   parameter int W = $clog2(N)
) (
   input  logic [W:0]   req_rel_i,
   input  logic [W:0]   isr_rel_i,
   input  logic [W-1:0] origin_i,
   input  logic         bypass_i,
   output logic         raise_o,
   output logic [W-1:0] line_o
);
   logic [W:0] limit;

   always_comb begin
      limit   = bypass_i ? (W+1)'(N) : isr_rel_i;
      raise_o = (req_rel_i < limit);
      line_o  = raise_o ? W'(req_rel_i + {1'b0, origin_i}) : '0;
   end
endmodule

// File: rtl/rpr_top.sv
module rpr_top
   import rpr_pkg::*;
#(
   parameter int NUM_LINES    = RPR_LINES,
   parameter int CASCADE_LINE = RPR_CASCADE,
   localparam int IDX_W       = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] req_i,
   input  logic [NUM_LINES-1:0] mask_i,
   input  logic [NUM_LINES-1:0] insvc_i,
   input  logic [IDX_W-1:0]     origin_i,
   input  logic                 master_i,
   input  logic                 nest_i,
   input  logic                 smask_i,
   output logic                 irq_o,
   output logic [IDX_W-1:0]     line_o
);
   generate
      if (NUM_LINES < 2 || NUM_LINES != (1 << IDX_W)) begin : g_bad_lines
         $error("rpr_top: NUM_LINES must be a power of two, at least 2");
      end
      if (CASCADE_LINE < 0 || CASCADE_LINE >= NUM_LINES) begin : g_bad_cascade
         $error("rpr_top: CASCADE_LINE out of range");
      end
   endgenerate

   logic [NUM_LINES-1:0] cand;
   logic [NUM_LINES-1:0] isr_eff;
   logic [IDX_W:0]       req_rel;
   logic [IDX_W:0]       isr_rel;
   logic                 raise;
   logic [IDX_W-1:0]     line_d;

   always_comb begin
      cand    = req_i & ~mask_i;
      isr_eff = insvc_i;
      if (master_i && nest_i) isr_eff[CASCADE_LINE] = 1'b0;
   end

   rpr_find #(.N(NUM_LINES), .W(IDX_W)) u_find_req (
      .vec_i(cand), .origin_i(origin_i), .rel_o(req_rel));

   rpr_find #(.N(NUM_LINES), .W(IDX_W)) u_find_isr (
      .vec_i(isr_eff), .origin_i(origin_i), .rel_o(isr_rel));

   rpr_gate #(.N(NUM_LINES), .W(IDX_W)) u_gate (
      .req_rel_i(req_rel), .isr_rel_i(isr_rel), .origin_i(origin_i),
      .bypass_i(smask_i), .raise_o(raise), .line_o(line_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o  <= 1'b0;
         line_o <= '0;
      end else begin
         irq_o  <= raise;
         line_o <= line_d;
      end
   end

   // R10
   idle_line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> (line_o == '0));

   // R2
   no_cand_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cand == '0) |=> !irq_o);

   // R6
   empty_isr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insvc_i == '0 && cand != '0) |=> irq_o);

   // R9
   smask_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smask_i && cand != '0) |=> irq_o);

   // R3
   winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (!irq_o || ((($past(cand) >> line_o) & NUM_LINES'(1)) != '0)));

   // R5
   winner_not_serviced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!smask_i && !(master_i && nest_i)) |=>
         (!irq_o || ((($past(insvc_i) >> line_o) & NUM_LINES'(1)) == '0)));
endmodule

// File: tb/tb_rpr_top.sv
`timescale 1ns/1ps
module tb_rpr_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_i = '0, mask_i = '0, insvc_i = '0;
   logic [2:0] origin_i = '0;
   logic       master_i = 1'b0, nest_i = 1'b0, smask_i = 1'b0;
   logic       irq_o;
   logic [2:0] line_o;

   int compared = 0;
   int mismatched = 0;

   always #4 clk = ~clk;

   rpr_top dut (.clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i),
      .insvc_i(insvc_i), .origin_i(origin_i), .master_i(master_i),
      .nest_i(nest_i), .smask_i(smask_i), .irq_o(irq_o), .line_o(line_o));

   // tag(4) req(8) mask(8) isr(8) origin(3) master nest smask exp_irq exp_line(3)
   localparam int NV = 19;
   localparam logic [37:0] TBL [NV] = '{
      {4'd10, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
      {4'd6,  8'h10, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4},
      {4'd3,  8'h12, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1},
      {4'd3,  8'h12, 8'h00, 8'h00, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4},
      {4'd3,  8'h12, 8'h00, 8'h00, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1},
      {4'd2,  8'h12, 8'h02, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4},
      {4'd2,  8'hFF, 8'hFF, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
      {4'd5,  8'h08, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
      {4'd5,  8'h08, 8'h00, 8'h02, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
      {4'd5,  8'h02, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1},
      {4'd5,  8'h02, 8'h00, 8'h40, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
      {4'd3,  8'h20, 8'h00, 8'h02, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5},
      {4'd7,  8'h08, 8'h00, 8'h04, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3},
      {4'd8,  8'h08, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
      {4'd8,  8'h08, 8'h00, 8'h04, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
      {4'd7,  8'h08, 8'h00, 8'h05, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
      {4'd9,  8'h80, 8'h00, 8'h01, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd7},
      {4'd10, 8'h00, 8'h00, 8'hFF, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
      {4'd2,  8'h80, 8'h80, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0}
   };

   function automatic string tag_name(input logic [3:0] t);
      case (t)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6: return "R6";
         4'd7: return "R7";
         4'd8: return "R8";
         4'd9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input string tag, input logic e_irq, input logic [2:0] e_line);
      compared++;
      if (irq_o !== e_irq || line_o !== e_line) begin
         mismatched++;
         $display("FAIL %s: irq=%0b line=%0d expected irq=%0b line=%0d",
                  tag, irq_o, line_o, e_irq, e_line);
      end
   endtask

   task automatic drive(input logic [37:0] v);
      req_i    = v[33:26];
      mask_i   = v[25:18];
      insvc_i  = v[17:10];
      origin_i = v[9:7];
      master_i = v[6];
      nest_i   = v[5];
      smask_i  = v[4];
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      mismatched++;
      compared++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      // R1: outputs held low under reset with active inputs
      req_i = 8'hFF;
      repeat (3) @(negedge clk);
      chk("R1", 1'b0, 3'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6", 1'b1, 3'd0);

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         drive(TBL[k]);
         @(negedge clk);
         chk(tag_name(TBL[k][37:34]), TBL[k][3], TBL[k][2:0]);
      end

      // R4: output waits for the next edge
      @(negedge clk);
      drive({4'd4, 8'h40, 8'h00, 8'h00, 3'd0, 4'b0000, 3'd0});
      #1;
      chk("R4", 1'b0, 3'd0);
      @(posedge clk);
      #1;
      chk("R4", 1'b1, 3'd6);

      // R1: reset mid-run clears registered outputs
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", 1'b0, 3'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4", 1'b1, 3'd6);

      // R7: nested master, every rotation, only cascade in service
      for (int o = 0; o < 8; o++) begin
         @(negedge clk);
         drive({4'd7, 8'h08, 8'h00, 8'h04, 3'(o), 1'b1, 1'b1, 1'b0, 1'b0, 3'd0});
         @(negedge clk);
         chk("R7", 1'b1, 3'd3);
      end
      finish_run();
   end
endmodule